// File: doc/BRIEF.md
# One-Time-Programmable Array Programming Controller

This block lets a host processor program and read back a one-time-programmable (OTP) array while the chip is in a host programming mode. The host reaches three registers over a simple peripheral bus: an address register, a data register and an operation control register. A program request writes one 16-bit half of a 32-bit array entry. It applies a single pulse of fixed length, and no verify loop follows. Erased cells hold ones, so programming can only clear bits.

Programming mode is latched from a strap pin at the end of reset. The default of the external bus enable is latched from an external-access pin at the same time. A voltage-present input stands in for the analog programming supply. A program request is refused unless the chip is in programming mode and this input is high. While in programming mode, the normal data read port returns zero unless the control register holds a read operation.

Top module: `otp_prog_ctrl`

## Requirements
- R1: At the first clock edge after reset is released, `pgm_mode` takes the inverse of `prog_strap_n`. It then holds that value until the next reset.
- R2: At that same edge, `ext_bus_en` takes the inverse of `ext_acc_pin`, so a low pin enables the external bus and a high pin disables it.
- R3: Register select on `bus_reg`: 0 is the address register, 1 is the data register, 2 is the control register, and 3 reads zero. The control register layout is: bits [1:0] the operation (00 idle, 01 program, 10 read), bit 2 busy, bit 3 done, bit 4 error. All of these read 0 after reset.
- R4: An accepted program request sets busy for exactly `PULSE_CYC` cycles. When busy clears, the operation field returns to 00 and done reads 1. Any later accepted control write clears done.
- R5: A program operation stores the old 16-bit half ANDed with the data register. Erased halves read FFFFh.
- R6: Address bit 0 picks the half of entry `addr>>1`: 0 is bits [15:0] and 1 is bits [31:16]. The other half is left unchanged.
- R7: A program request made outside programming mode or with `vpp_ok` low starts nothing and sets the error bit. The error bit stays set until a control write with bit 4 = 1 clears it.
- R8: While busy is set, bus writes to the address, data and control registers are ignored.
- R9: Writing operation 10 loads the data register, on the next edge, with the half selected by the address register, and sets done. In programming mode, `rd_data` reads 0000h unless the operation field is 10. Outside programming mode, it returns the selected stored half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_strap_n | input | 1 | Strap pin; low at end of reset selects programming mode |
| ext_acc_pin | input | 1 | External-access pin; sets the external bus default |
| vpp_ok | input | 1 | Programming voltage present |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| rd_addr | input | AW | Normal data read address (bit 0 selects the half) |
| rd_data | output | 16 | Normal data read result |
| pgm_mode | output | 1 | Programming mode latched at reset |
| ext_bus_en | output | 1 | External bus enable default |

## Verification
The hardest situation to reach is a bus write that lands while a pulse is in flight. The bench issues address and data writes in the cycles right after a program start. It then reads both registers back and the control word before busy falls, and checks that the committed half reflects the pre-busy values. A second program on the same half checks the AND merge. Reset is cycled with different strap and external-access levels to cover both mode outcomes.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PROG = 2'b01,
    OP_READ = 2'b10
  } otp_op_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_BUSY = 2;
  localparam int CTRL_DONE = 3;
  localparam int CTRL_ERR  = 4;

  function automatic logic [15:0] pick_half(input logic [31:0] word, input logic hi);
    return hi ? word[31:16] : word[15:0];
  endfunction

  function automatic logic [31:0] burn_half(input logic [31:0] word, input logic hi,
                                            input logic [15:0] val);
    logic [31:0] res;
    res = word;
    if (hi) res[31:16] = word[31:16] & val;
    else    res[15:0]  = word[15:0] & val;
    return res;
  endfunction
endpackage

// File: rtl/otp_mode_latch.sv
module otp_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_strap_n,
  input  logic ext_acc_pin,
  output logic pgm_mode,
  output logic ext_bus_en
);
  logic captured;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured   <= 1'b0;
      pgm_mode   <= 1'b0;
      ext_bus_en <= 1'b0;
    end else if (!captured) begin
      captured   <= 1'b1;
      pgm_mode   <= ~prog_strap_n;
      ext_bus_en <= ~ext_acc_pin;
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(captured) && captured) |-> ($stable(pgm_mode) && $stable(ext_bus_en))); // R1
endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int PULSE_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

  logic [CW-1:0] cnt;

  assign fire = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LOAD)); // R4
  AST_FIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy); // R4
endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pr_en,
  input  logic [$clog2(DEPTH)-1:0] pr_idx,
  input  logic                     pr_hi,
  input  logic [15:0]              pr_val,
  input  logic [$clog2(DEPTH)-1:0] ra_idx,
  output logic [31:0]              ra_word,
  input  logic [$clog2(DEPTH)-1:0] rb_idx,
  output logic [31:0]              rb_word
);
  logic [31:0] cells [DEPTH];
  logic [31:0] pr_old;

  assign pr_old  = cells[pr_idx];
  assign ra_word = cells[ra_idx];
  assign rb_word = cells[rb_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (pr_en) begin
      cells[pr_idx] <= burn_half(pr_old, pr_hi, pr_val);
    end
  end

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pr_en |=> ((cells[$past(pr_idx)] & ~$past(pr_old)) == 32'h0)); // R5
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int PULSE_CYC = 2500,
  parameter int AW        = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_strap_n,
  input  logic          ext_acc_pin,
  input  logic          vpp_ok,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_reg,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic          pgm_mode,
  output logic          ext_bus_en
);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  otp_op_e       op_q;
  logic          done_q, err_q;
  logic          busy, fire;
  logic [31:0]   sel_word, port_word;

  // named internal events
  logic wr_any, wr_addr, wr_data, wr_ctrl;
  logic req_prog, req_read, prog_allowed, start_prog, reject_prog, err_clear;
  logic port_blocked;

  assign wr_any       = bus_sel && bus_wr && !busy;
  assign wr_addr      = wr_any && (bus_reg == SEL_ADDR);
  assign wr_data      = wr_any && (bus_reg == SEL_DATA);
  assign wr_ctrl      = wr_any && (bus_reg == SEL_CTRL);
  assign req_prog     = wr_ctrl && (bus_wdata[1:0] == OP_PROG);
  assign req_read     = wr_ctrl && (bus_wdata[1:0] == OP_READ);
  assign prog_allowed = pgm_mode && vpp_ok;
  assign start_prog   = req_prog && prog_allowed;
  assign reject_prog  = req_prog && !prog_allowed;
  assign err_clear    = wr_ctrl && bus_wdata[CTRL_ERR];

  otp_mode_latch u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_strap_n (prog_strap_n),
    .ext_acc_pin  (ext_acc_pin),
    .pgm_mode     (pgm_mode),
    .ext_bus_en   (ext_bus_en)
  );

  otp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_prog),
    .busy  (busy),
    .fire  (fire)
  );

  otp_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .pr_en   (fire),
    .pr_idx  (addr_q[AW-1:1]),
    .pr_hi   (addr_q[0]),
    .pr_val  (data_q),
    .ra_idx  (addr_q[AW-1:1]),
    .ra_word (sel_word),
    .rb_idx  (rd_addr[AW-1:1]),
    .rb_word (port_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      op_q   <= OP_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= bus_wdata[AW-1:0];
      if (wr_data) data_q <= bus_wdata;
      if (req_read) data_q <= pick_half(sel_word, addr_q[0]);
      if (wr_ctrl) begin
        done_q <= req_read;
        if (start_prog)    op_q <= OP_PROG;
        else if (req_read) op_q <= OP_READ;
        else               op_q <= OP_IDLE;
      end
      if (fire) begin
        op_q   <= OP_IDLE;
        done_q <= 1'b1;
      end
      if (reject_prog)    err_q <= 1'b1;
      else if (err_clear) err_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_reg)
      SEL_ADDR: bus_rdata[AW-1:0] = addr_q;
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: begin
        bus_rdata[1:0]       = op_q;
        bus_rdata[CTRL_BUSY] = busy;
        bus_rdata[CTRL_DONE] = done_q;
        bus_rdata[CTRL_ERR]  = err_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign port_blocked = pgm_mode && (op_q != OP_READ);
  assign rd_data      = port_blocked ? 16'h0000 : pick_half(port_word, rd_addr[0]);

  AST_BUSY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pgm_mode && op_q == OP_PROG)); // R7
  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q))); // R8
  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_q && op_q == OP_IDLE)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clear) |=> err_q); // R7
  AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_mode && !busy && op_q == OP_IDLE) |-> (rd_data == 16'h0000)); // R9
endmodule

// File: tb/otp_prog_ctrl_bench.sv
module otp_prog_ctrl_bench;
  localparam int DEPTH = 64;
  localparam int PULSE = 20;
  localparam int AW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_strap_n = 1'b1, ext_acc_pin = 1'b0, vpp_ok = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_reg = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic pgm_mode, ext_bus_en;

  always #5 clk = ~clk;

  otp_prog_ctrl #(.DEPTH(DEPTH), .PULSE_CYC(PULSE)) u_otp_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_strap_n(prog_strap_n), .ext_acc_pin(ext_acc_pin),
    .vpp_ok(vpp_ok), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .pgm_mode(pgm_mode), .ext_bus_en(ext_bus_en)
  );

  typedef struct { int kind; logic [15:0] exp; string req; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0, cyc = 0;
  logic sample_req = 1'b0;
  logic finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] ctrl_word(input logic [1:0] op, input logic b,
                                            input logic d, input logic e);
    return {11'd0, e, d, b, op};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares with the selected output
  always @(negedge clk) begin
    if (sample_req && sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = rd_data;
        2: act = {15'd0, pgm_mode};
        default: act = {15'd0, ext_bus_en};
      endcase
      check(it.req, act, it.exp);
    end
  end

  task automatic expect_out(input int kind, input logic [1:0] sel, input logic [15:0] exp,
                            input string req);
    item_t it;
    @(posedge clk); #1;
    bus_sel = (kind == 0); bus_wr = 1'b0; bus_reg = sel;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
    sample_req = 1'b1;
    @(negedge clk); #1;
    sample_req = 1'b0;
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [15:0] val);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_reg = sel; bus_wdata = val;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_reset(input logic strap_n, input logic ea);
    @(posedge clk); #1;
    rst_n = 1'b0; prog_strap_n = strap_n; ext_acc_pin = ea;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 prog_strap_n = ~strap_n; ext_acc_pin = ~ea;  // later pin changes must not matter
  endtask

  task automatic wait_pulse(input int t0, input string req);
    int t1;
    bus_reg = 2'd2;
    for (int i = 0; i < 4 * PULSE; i++) begin
      @(negedge clk);
      if (bus_rdata[2] == 1'b0) break;
    end
    t1 = cyc;
    check(req, 16'(t1 - t0), 16'(PULSE));
  endtask

  task automatic program_half(input logic [15:0] a, input logic [15:0] d, input string req);
    int t0;
    bus_write(2'd0, a);
    bus_write(2'd1, d);
    bus_write(2'd2, 16'h0001);
    t0 = cyc;
    wait_pulse(t0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0;
    // ---------- normal mode: strap high, external-access low ----------
    do_reset(1'b1, 1'b0);
    expect_out(2, 2'd0, 16'h0000, "R1 normal mode");
    expect_out(3, 2'd0, 16'h0001, "R2 ea low enables bus");
    expect_out(0, 2'd2, 16'h0000, "R3 ctrl reset");
    expect_out(0, 2'd1, 16'h0000, "R3 data reset");
    expect_out(0, 2'd3, 16'h0000, "R3 select 3 reads zero");
    bus_write(2'd0, 16'h0005);
    bus_write(2'd1, 16'h1234);
    bus_write(2'd2, 16'h0001);
    expect_out(0, 2'd2, ctrl_word(2'b00, 1'b0, 1'b0, 1'b1), "R7 reject outside mode");
    rd_addr = 7'd5;
    expect_out(1, 2'd0, 16'hFFFF, "R9 normal port reads stored");
    expect_out(1, 2'd0, 16'hFFFF, "R7 array untouched on reject");

    // ---------- programming mode: strap low, external-access high ----------
    vpp_ok = 1'b0;
    do_reset(1'b0, 1'b1);
    expect_out(2, 2'd0, 16'h0001, "R1 programming mode");
    expect_out(3, 2'd0, 16'h0000, "R2 ea high disables bus");
    rd_addr = 7'd5;
    expect_out(1, 2'd0, 16'h0000, "R9 blocked read returns zero");
    bus_write(2'd0, 16'h0005);
    bus_write(2'd1, 16'hA5F0);
    bus_write(2'd2, 16'h0001);
    expect_out(0, 2'd2, ctrl_word(2'b00, 1'b0, 1'b0, 1'b1), "R7 reject without vpp");
    bus_write(2'd2, 16'h0000);
    expect_out(0, 2'd2, ctrl_word(2'b00, 1'b0, 1'b0, 1'b1), "R7 error sticky");
    bus_write(2'd2, 16'h0010);
    expect_out(0, 2'd2, 16'h0000, "R7 error cleared");

    vpp_ok = 1'b1;
    bus_write(2'd2, 16'h0001);
    t0 = cyc;
    bus_write(2'd0, 16'h0009);
    bus_write(2'd1, 16'h0000);
    bus_write(2'd2, 16'h0010);
    expect_out(0, 2'd0, 16'h0005, "R8 addr write ignored while busy");
    expect_out(0, 2'd1, 16'hA5F0, "R8 data write ignored while busy");
    expect_out(0, 2'd2, ctrl_word(2'b01, 1'b1, 1'b0, 1'b0), "R4 busy state");
    wait_pulse(t0, "R4 pulse length");
    expect_out(0, 2'd2, ctrl_word(2'b00, 1'b0, 1'b1, 1'b0), "R4 done after pulse");

    bus_write(2'd2, 16'h0002);
    expect_out(0, 2'd1, 16'hA5F0, "R9 read op loads data");
    expect_out(0, 2'd2, ctrl_word(2'b10, 1'b0, 1'b1, 1'b0), "R9 read op done");
    rd_addr = 7'd5;
    expect_out(1, 2'd0, 16'hA5F0, "R6 upper half programmed");
    rd_addr = 7'd4;
    expect_out(1, 2'd0, 16'hFFFF, "R6 lower half untouched");

    program_half(16'h0005, 16'h0F0F, "R4 second pulse length");
    bus_write(2'd2, 16'h0002);
    expect_out(0, 2'd1, 16'h0500, "R5 and-merge of two programs");

    program_half(16'h0004, 16'h1234, "R4 third pulse length");
    bus_write(2'd0, 16'h0004);
    bus_write(2'd2, 16'h0002);
    expect_out(0, 2'd1, 16'h1234, "R6 lower half programmed");
    rd_addr = 7'd5;
    expect_out(1, 2'd0, 16'h0500, "R6 upper half kept");
    bus_write(2'd2, 16'h0000);
    expect_out(0, 2'd2, 16'h0000, "R4 done cleared by ctrl write");
    expect_out(1, 2'd0, 16'h0000, "R9 blocked again when idle");

    // ---------- programming mode with external-access low ----------
    do_reset(1'b0, 1'b0);
    expect_out(3, 2'd0, 16'h0001, "R2 ea low in programming mode");
    expect_out(2, 2'd0, 16'h0001, "R1 mode held after strap moves");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule